// File: doc/BRIEF.md
# Three-Channel Edge Skew Detector

This block measures the timing offset between the rising edges of three video channels (red, green, blue). Each channel arrives as a signed digital sample word. Each word is compared against a shared slice threshold, and the result is a one-bit level per channel. The threshold comes from a 4-bit signed slice code whose scale depends on a gain-mode bit.

The three channels form three fixed pairs. For each pair, the block raises a polarity-tagged pulse from the first rising edge to the second. The pulse is positive when the first-named channel leads and negative when the other leads. When a measurement completes, its signed width in clock cycles is added to a per-pair accumulator, and a per-pair edge counter advances.

A measurement needs the two levels to be high together. If the leading level drops before the lagging one rises, the measurement is thrown away and a sticky per-pair error flag is set. A clear input empties the accumulators, the counters and the error flags. Software or a control loop reads the accumulated sum and the count, and divides them to get the mean skew of each pair.

Top module: `edge_skew_monitor`

## Requirements
- R1: A channel level is high only when its sample is strictly greater than the threshold. Equality reads as low. The threshold in sample LSBs is `code * 2 * LSB_PER_STEP` when `gain_x2_i` is 0 and `code * LSB_PER_STEP` when it is 1. The code is the two's-complement value of `slice_code_i` (range -8..+7).
- R2: A change of `slice_code_i` or `gain_x2_i` alters the threshold applied to later samples with no other action. Samples that are unchanged but are newly above the threshold produce rising edges.
- R3: When A rises d >= 1 cycles before B and A is still high when B rises: `pulse_pos_o` of that pair is high for exactly d cycles, the accumulator gains +d, and the edge counter gains 1.
- R4: When B rises d >= 1 cycles before A and B is still high when A rises: `pulse_neg_o` of that pair is high for exactly d cycles, the accumulator gains -d, and the edge counter gains 1.
- R5: When both levels of a pair rise in the same cycle, the counter gains 1, the accumulator is unchanged, and neither pulse output rises.
- R6: If the leading level is low in the cycle where the lagging level rises, or is low before that, the measurement is discarded. Accumulator and counter keep their values, and the pair's error flag goes high and stays high until a clear.
- R7: Pair 0 is red (A) vs green (B), pair 1 is green (A) vs blue (B), and pair 2 is blue (A) vs red (B). Pair p occupies bits `[p*ACC_W +: ACC_W]` of `skew_acc_o` and `[p*CNT_W +: CNT_W]` of `edge_cnt_o`, and bit p of each 3-bit output.
- R8: A cycle with `clear_i` high zeroes every accumulator, counter and error flag. If a measurement completes in that same cycle, the accumulator holds that result alone and the counter holds 1.
- R9: After reset, all pulse outputs, accumulators, counters and error flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_r_i | input | SAMPLE_W | Red channel sample, signed |
| sample_g_i | input | SAMPLE_W | Green channel sample, signed |
| sample_b_i | input | SAMPLE_W | Blue channel sample, signed |
| slice_code_i | input | 4 | Signed slice threshold code |
| gain_x2_i | input | 1 | 1 = double-gain scale (half-size step) |
| clear_i | input | 1 | Clears accumulators, counters and error flags |
| pulse_pos_o | output | 3 | Per pair: A leads, measurement open |
| pulse_neg_o | output | 3 | Per pair: B leads, measurement open |
| skew_acc_o | output | 3*ACC_W | Per pair signed sum of measured skews |
| edge_cnt_o | output | 3*CNT_W | Per pair count of completed measurements |
| overlap_err_o | output | 3 | Per pair sticky discarded-measurement flag |

## Verification
The delicate coincidence is a measurement completing in the same cycle that `clear_i` is high. The bench preloads a pair's accumulator with an earlier result. It then raises the clear exactly in the cycle where the lagging edge closes the next measurement, and expects the accumulator to equal only the new skew, with a count of one. A second coincidence is the leading level falling in the very cycle the lagging level rises. That case is driven on one negative edge, and the bench expects a discard with the error flag set and the counter unchanged.

// File: rtl/skew_pkg.sv
package skew_pkg;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    PAIR_IDLE   = 2'd0,
    PAIR_A_LEAD = 2'd1,
    PAIR_B_LEAD = 2'd2
  } pair_state_e;
endpackage

// File: rtl/slice_threshold.sv
module slice_threshold #(
  parameter int SAMPLE_W     = 12,
  parameter int LSB_PER_STEP = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [3:0]                 code_i,
  input  logic                       gain_x2_i,
  output logic signed [SAMPLE_W-1:0] thr_o
);
  localparam int UNITY_STEP = 2 * LSB_PER_STEP;

  logic signed [SAMPLE_W-1:0] code_ext;
  logic signed [SAMPLE_W-1:0] step;
  logic signed [SAMPLE_W-1:0] thr_d;
  logic signed [SAMPLE_W-1:0] thr_q;

  always_comb begin
    code_ext = SAMPLE_W'($signed(code_i));
    step     = gain_x2_i ? SAMPLE_W'(LSB_PER_STEP) : SAMPLE_W'(UNITY_STEP);
    thr_d    = code_ext * step;
  end

  // recomputed every cycle, so code or gain changes take effect on the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= '0;
    else         thr_q <= thr_d;
  end

  assign thr_o = thr_q;

  // R2: unchanged inputs leave the threshold alone
  a_r2_thr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(code_i) && $stable(gain_x2_i)) |=> $stable(thr_q));
endmodule

// File: rtl/level_slicer.sv
module level_slicer #(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [SAMPLE_W-1:0] thr_i,
  output logic                       lvl_o,
  output logic                       rise_o
);
  logic lvl_q;
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lvl_q  <= sample_i > thr_i;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;

  // R1: a rising level needs the previous sample strictly above the threshold
  a_r1_rise_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> ($past(sample_i) > $past(thr_i)));
endmodule

// File: rtl/pair_skew_meter.sv
module pair_skew_meter
  import skew_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int CNT_W = 16,
  parameter int RUN_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lvl_a_i,
  input  logic                    rise_a_i,
  input  logic                    lvl_b_i,
  input  logic                    rise_b_i,
  input  logic                    clear_i,
  output logic                    pos_o,
  output logic                    neg_o,
  output logic signed [ACC_W-1:0] acc_o,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    err_o
);
  typedef logic signed [ACC_W-1:0] acc_t;

  pair_state_e      state_q, state_d;
  logic [RUN_W-1:0] run_q;
  logic             done;
  logic             abort;
  acc_t             result;
  acc_t             acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    abort   = 1'b0;
    result  = '0;
    unique case (state_q)
      PAIR_IDLE: begin
        if (rise_a_i && rise_b_i) begin
          done = 1'b1;
        end else if (rise_a_i) begin
          state_d = PAIR_A_LEAD;
        end else if (rise_b_i) begin
          state_d = PAIR_B_LEAD;
        end
      end
      PAIR_A_LEAD: begin
        if (rise_b_i && lvl_a_i) begin
          done    = 1'b1;
          result  = acc_t'(run_q);
          state_d = PAIR_IDLE;
        end else if (!lvl_a_i) begin
          abort   = 1'b1;
          state_d = PAIR_IDLE;
        end
      end
      PAIR_B_LEAD: begin
        if (rise_a_i && lvl_b_i) begin
          done    = 1'b1;
          result  = -acc_t'(run_q);
          state_d = PAIR_IDLE;
        end else if (!lvl_b_i) begin
          abort   = 1'b1;
          state_d = PAIR_IDLE;
        end
      end
      default: state_d = PAIR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PAIR_IDLE;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      // run counts cycles since the leading edge, saturating
      if (state_q == PAIR_IDLE)  run_q <= RUN_W'(1);
      else if (run_q != '1)      run_q <= run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (clear_i) begin
      acc_q <= done ? result : '0;
      cnt_q <= done ? CNT_W'(1) : '0;
      err_q <= abort;
    end else begin
      if (done) begin
        acc_q <= acc_q + result;
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (abort) err_q <= 1'b1;
    end
  end

  assign pos_o = (state_q == PAIR_A_LEAD);
  assign neg_o = (state_q == PAIR_B_LEAD);
  assign acc_o = acc_q;
  assign cnt_o = cnt_q;
  assign err_o = err_q;

  a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r3_acc_with_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (acc_q == $past(acc_q)) || (cnt_q != $past(cnt_q)));

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clear_i) |=> err_q);

  a_r6_pos_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o && !lvl_a_i && !clear_i) |=> (err_q && !pos_o && cnt_q == $past(cnt_q)));

  a_r4_neg_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (neg_o && !lvl_b_i && !clear_i) |=> (err_q && !neg_o && cnt_q == $past(cnt_q)));

  a_r8_clear_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0 || cnt_q == CNT_W'(1)));
endmodule

// File: rtl/edge_skew_monitor.sv
module edge_skew_monitor
  import skew_pkg::*;
#(
  parameter int SAMPLE_W     = 12,
  parameter int LSB_PER_STEP = 4,
  parameter int ACC_W        = 24,
  parameter int CNT_W        = 16,
  parameter int RUN_W        = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_r_i,
  input  logic signed [SAMPLE_W-1:0] sample_g_i,
  input  logic signed [SAMPLE_W-1:0] sample_b_i,
  input  logic [3:0]                 slice_code_i,
  input  logic                       gain_x2_i,
  input  logic                       clear_i,
  output logic [NUM_CH-1:0]          pulse_pos_o,
  output logic [NUM_CH-1:0]          pulse_neg_o,
  output logic [NUM_CH*ACC_W-1:0]    skew_acc_o,
  output logic [NUM_CH*CNT_W-1:0]    edge_cnt_o,
  output logic [NUM_CH-1:0]          overlap_err_o
);
  logic signed [SAMPLE_W-1:0] thr;
  logic signed [SAMPLE_W-1:0] smp [NUM_CH];
  logic [NUM_CH-1:0]          lvl;
  logic [NUM_CH-1:0]          rise;

  assign smp[0] = sample_r_i;
  assign smp[1] = sample_g_i;
  assign smp[2] = sample_b_i;

  slice_threshold #(
    .SAMPLE_W     (SAMPLE_W),
    .LSB_PER_STEP (LSB_PER_STEP)
  ) u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (slice_code_i),
    .gain_x2_i (gain_x2_i),
    .thr_o     (thr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    level_slicer #(.SAMPLE_W(SAMPLE_W)) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (smp[c]),
      .thr_i    (thr),
      .lvl_o    (lvl[c]),
      .rise_o   (rise[c])
    );
  end

  // pair p: channel p is A, the next channel (wrapping) is B
  for (genvar p = 0; p < NUM_CH; p++) begin : g_pair
    localparam int PB = (p + 1) % NUM_CH;
    logic signed [ACC_W-1:0] acc_w;

    pair_skew_meter #(
      .ACC_W (ACC_W),
      .CNT_W (CNT_W),
      .RUN_W (RUN_W)
    ) u_meter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lvl_a_i  (lvl[p]),
      .rise_a_i (rise[p]),
      .lvl_b_i  (lvl[PB]),
      .rise_b_i (rise[PB]),
      .clear_i  (clear_i),
      .pos_o    (pulse_pos_o[p]),
      .neg_o    (pulse_neg_o[p]),
      .acc_o    (acc_w),
      .cnt_o    (edge_cnt_o[p*CNT_W +: CNT_W]),
      .err_o    (overlap_err_o[p])
    );

    assign skew_acc_o[p*ACC_W +: ACC_W] = acc_w;
  end

  // R7: a pair never signals both lead directions at once
  a_r7_one_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_pos_o & pulse_neg_o) == '0);
endmodule

// File: tb/tb_edge_skew_monitor.sv
module tb_edge_skew_monitor;
  localparam int SW   = 12;
  localparam int K    = 4;
  localparam int AW   = 24;
  localparam int CW   = 16;
  localparam int LOWV = -2000;
  localparam int HIV  = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [SW-1:0] smp [3];
  logic [3:0]  code = 4'd0;
  logic        gain = 1'b0;
  logic        clr  = 1'b0;
  logic [2:0]  pos, neg, err;
  logic [3*AW-1:0] acc;
  logic [3*CW-1:0] cnt;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  edge_skew_monitor #(.SAMPLE_W(SW), .LSB_PER_STEP(K), .ACC_W(AW), .CNT_W(CW), .RUN_W(12)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sample_r_i(smp[0]), .sample_g_i(smp[1]), .sample_b_i(smp[2]),
    .slice_code_i(code), .gain_x2_i(gain), .clear_i(clr),
    .pulse_pos_o(pos), .pulse_neg_o(neg),
    .skew_acc_o(acc), .edge_cnt_o(cnt), .overlap_err_o(err)
  );

  function automatic int acc_of(int p);
    logic signed [AW-1:0] v;
    v = acc[p*AW +: AW];
    return int'(v);
  endfunction

  function automatic int cnt_of(int p);
    return int'(cnt[p*CW +: CW]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic all_low();
    @(negedge clk);
    for (int c = 0; c < 3; c++) smp[c] = LOWV[SW-1:0];
    repeat (4) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // d>0: A leads by d, d<0: B leads by |d|, d==0: together. Returns pulse cycles seen.
  task automatic run_edge(int p, int d, bit clr_at_done, output int width);
    int a, b, first, second, mag;
    a = p; b = (p + 1) % 3;
    first  = (d >= 0) ? a : b;
    second = (d >= 0) ? b : a;
    mag    = (d < 0) ? -d : d;
    width  = 0;
    @(negedge clk);
    smp[first] = HIV[SW-1:0];
    if (d == 0) smp[second] = HIV[SW-1:0];
    for (int i = 0; i < mag; i++) begin
      @(negedge clk);
      width += (d > 0) ? int'(pos[p]) : int'(neg[p]);
    end
    smp[second] = HIV[SW-1:0];
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      clr = (i == 0) && clr_at_done;
      width += (d > 0) ? int'(pos[p]) : (d < 0) ? int'(neg[p]) : int'(pos[p] | neg[p]);
    end
    clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 pos", int'(pos), 0);
    chk("R9 neg", int'(neg), 0);
    chk("R9 err", int'(err), 0);
    for (int p = 0; p < 3; p++) begin
      chk("R9 acc", acc_of(p), 0);
      chk("R9 cnt", cnt_of(p), 0);
    end
  endtask

  task automatic t_a_leads();
    int w;
    do_clear();
    run_edge(0, 3, 1'b0, w);
    chk("R3 width", w, 3);
    chk("R3 acc", acc_of(0), 3);
    chk("R3 cnt", cnt_of(0), 1);
    chk("R3 err", int'(err[0]), 0);
    all_low();
    run_edge(0, 5, 1'b0, w);
    chk("R3 acc sum", acc_of(0), 8);
    chk("R3 cnt sum", cnt_of(0), 2);
    all_low();
    run_edge(0, 1, 1'b0, w);
    chk("R3 width one", w, 1);
    chk("R3 acc one", acc_of(0), 9);
    all_low();
  endtask

  task automatic t_b_leads();
    int w;
    do_clear();
    run_edge(1, -4, 1'b0, w);
    chk("R4 width", w, 4);
    chk("R4 acc", acc_of(1), -4);
    chk("R4 cnt", cnt_of(1), 1);
    all_low();
  endtask

  task automatic t_pair_map();
    int w;
    do_clear();
    run_edge(2, 2, 1'b0, w);   // blue then red
    chk("R7 pair2 acc", acc_of(2), 2);
    chk("R7 pair2 cnt", cnt_of(2), 1);
    chk("R7 pair0 open (red high, green low)", int'(pos[0]), 1);
    chk("R7 pair0 cnt", cnt_of(0), 0);
    all_low();
  endtask

  task automatic t_same_edge();
    int w;
    do_clear();
    run_edge(0, 0, 1'b0, w);
    chk("R5 no pulse", w, 0);
    chk("R5 acc", acc_of(0), 0);
    chk("R5 cnt", cnt_of(0), 1);
    all_low();
  endtask

  task automatic t_no_overlap();
    int w;
    do_clear();
    @(negedge clk); smp[1] = HIV[SW-1:0];
    repeat (2) @(negedge clk);
    smp[1] = LOWV[SW-1:0];
    repeat (3) @(negedge clk);
    smp[2] = HIV[SW-1:0];
    repeat (4) @(negedge clk);
    chk("R6 err", int'(err[1]), 1);
    chk("R6 cnt", cnt_of(1), 0);
    chk("R6 acc", acc_of(1), 0);
    all_low();
    run_edge(1, 2, 1'b0, w);
    chk("R6 later acc", acc_of(1), 2);
    chk("R6 sticky err", int'(err[1]), 1);
    all_low();
  endtask

  task automatic t_fall_meets_rise();
    do_clear();
    @(negedge clk); smp[1] = HIV[SW-1:0];
    repeat (3) @(negedge clk);
    smp[1] = LOWV[SW-1:0];
    smp[2] = HIV[SW-1:0];
    repeat (4) @(negedge clk);
    chk("R6 same-cycle err", int'(err[1]), 1);
    chk("R6 same-cycle cnt", cnt_of(1), 0);
    all_low();
  endtask

  task automatic t_clear_coincide();
    int w;
    do_clear();
    run_edge(0, 3, 1'b0, w);
    chk("R8 preload", acc_of(0), 3);
    all_low();
    run_edge(0, 5, 1'b1, w);
    chk("R8 coincide acc", acc_of(0), 5);
    chk("R8 coincide cnt", cnt_of(0), 1);
    all_low();
    do_clear();
    @(negedge clk);
    chk("R8 plain acc", acc_of(0), 0);
    chk("R8 plain cnt", cnt_of(0), 0);
    chk("R8 plain err", int'(err), 0);
  endtask

  task automatic t_thresh(int c, bit g);
    int thr;
    thr = c * (g ? K : 2 * K);
    @(negedge clk); code = 4'(c); gain = g;
    repeat (3) @(negedge clk);
    do_clear();
    @(negedge clk);
    smp[0] = SW'(thr + 1);
    smp[1] = SW'(thr);
    repeat (4) @(negedge clk);
    chk("R1 above opens", int'(pos[0]), 1);
    chk("R1 equal stays low", cnt_of(0), 0);
    smp[1] = SW'(thr + 1);
    repeat (4) @(negedge clk);
    chk("R1 closes", cnt_of(0), 1);
    chk("R1 pulse ended", int'(pos[0]), 0);
    all_low();
  endtask

  task automatic t_retune();
    @(negedge clk); code = 4'd2; gain = 1'b0;   // 16 LSB
    smp[0] = 12'sd10; smp[1] = 12'sd10;
    repeat (3) @(negedge clk);
    do_clear();
    repeat (2) @(negedge clk);
    chk("R2 below", cnt_of(0), 0);
    code = 4'd1;                                // 8 LSB
    repeat (4) @(negedge clk);
    chk("R2 code change cnt", cnt_of(0), 1);
    chk("R2 code change acc", acc_of(0), 0);
    all_low();
    @(negedge clk); code = 4'd4; gain = 1'b0;   // 32 LSB
    smp[0] = 12'sd20; smp[1] = 12'sd20;
    repeat (3) @(negedge clk);
    do_clear();
    repeat (2) @(negedge clk);
    chk("R2 gain below", cnt_of(0), 0);
    gain = 1'b1;                                // 16 LSB
    repeat (4) @(negedge clk);
    chk("R2 gain change cnt", cnt_of(0), 1);
    all_low();
    code = 4'd0; gain = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) smp[c] = LOWV[SW-1:0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_a_leads();
    t_b_leads();
    t_pair_map();
    t_same_edge();
    t_no_overlap();
    t_fall_meets_rise();
    t_clear_coincide();
    t_thresh(-3, 1'b0);
    t_thresh(5, 1'b1);
    t_thresh(-8, 1'b1);
    t_thresh(7, 1'b0);
    @(negedge clk); code = 4'd0; gain = 1'b0;
    t_retune();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule